// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines low-order bits of the branch address with the outcomes of the most recently resolved branches. A table row is chosen by the address. Within that row, the recent-outcome pattern held in a small global history register chooses one of several 2-bit saturating counters. The most significant bit of that counter is the prediction. The lookup is purely combinational, so a fetch stage gets its answer in the cycle it presents the address.

When a branch resolves, the pipeline returns the row index and history pattern that the block reported at lookup time, together with the real outcome. The block trains only the counter those two values name. It then shifts the outcome into the global history, with the newest outcome at bit 0. By default the table has 1024 rows and the history is 2 bits wide, so each row holds four counters. The address is not tag-checked, so branches whose low address bits match share a row.

Top module: `bp_corr_predictor`

## Requirements
- R1: After reset every counter holds the weakly not-taken value 01, so every lookup predicts not-taken, and the reported history `lk_hist` is all zeros.
- R2: The row index `lk_idx` equals `lk_pc[IDX_W+1:2]`, where IDX_W = log2(ENTRIES). PC bits 1:0 and all bits above IDX_W+1 have no effect on the index or the prediction.
- R3: `lk_taken` shows, in the same cycle as `lk_pc`, bit 1 (the MSB) of the counter at row `lk_idx`, slot `lk_hist`. A value of 1 means taken.
- R4: A cycle with `up_valid` high changes the counter at row `up_idx`, slot `up_hist`. It goes up by one when `up_taken` is 1, stopping at 3. It goes down by one when `up_taken` is 0, stopping at 0.
- R5: An update leaves every other counter unchanged, both in its own row and in other rows.
- R6: After an update, the history equals the old history shifted left by one, with `up_taken` placed in bit 0 and the oldest bit dropped. The counter write uses the passed-in `up_hist`, not the live history.
- R7: A cycle with `up_valid` low changes no counter and does not change the history, whatever the other update inputs carry.
- R8: From a strong state (00 or 11), the prediction flips only after two opposite outcomes in a row for that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_idx | output | IDX_W | Row index used by this lookup; returned with the update |
| lk_hist | output | HIST_W | Global history used by this lookup; returned with the update |
| up_valid | input | 1 | Marks a resolved branch in this cycle |
| up_idx | input | IDX_W | Row index captured when the branch was predicted |
| up_hist | input | HIST_W | History pattern captured when the branch was predicted |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A wrong counter shows up at `lk_taken` as soon as the history register next holds that counter's slot pattern and its row is addressed. A wrong history shows up directly at `lk_hist` in the cycle after the update that caused it. For these reasons the bench reads back every row after every update, compares against an arithmetic model, and so exposes a wrong value within one update. An extra write into a neighbouring slot can only be seen once the history walks into that slot. So the directed sequences steer the history back to the slots they trained, and a long pseudo-random sweep drives the history through every pattern many times.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MAX = '1;
    localparam ctr_t CTR_MIN = '0;
    localparam ctr_t CTR_RST = ctr_t'(1);

    function automatic ctr_t ctr_next(ctr_t cur, logic taken);
        ctr_t res;
        if (taken) begin
            res = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
        end else begin
            res = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
        end
        return res;
    endfunction

endpackage

// File: rtl/bp_corr_index.sv
module bp_corr_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    // word-aligned fetch: the two low bits never select a row; upper bits are not tagged
    assign idx = pc[IDX_W+1:2];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[1:0], pc[PC_W-1:IDX_W+2]};

endmodule

// File: rtl/bp_corr_history.sv
module bp_corr_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] ghr
);

    typedef struct packed {
        logic [HIST_W-1:0] pattern;
    } hist_state_t;

    hist_state_t st_d, st_q;
    logic [HIST_W:0] widened;

    always_comb begin
        st_d    = st_q;
        widened = {st_q.pattern, bit_in};
        if (shift_en) begin
            st_d.pattern = widened[HIST_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ghr = st_q.pattern;

endmodule

// File: rtl/bp_corr_table.sv
module bp_corr_table
    import bp_corr_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int HIST_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    input  logic [HIST_W-1:0]          rd_sel,
    output ctr_t                       rd_ctr,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [HIST_W-1:0]          wr_sel,
    input  logic                       wr_taken,
    output ctr_t                       wr_cur
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int NSLOT = 1 << HIST_W;

    typedef logic [NSLOT-1:0][CTR_W-1:0] row_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        row_t             row;
    } wr_req_t;

    localparam row_t ROW_RST = {NSLOT{CTR_RST}};

    row_t    rows_q [ENTRIES];
    row_t    wr_row;
    row_t    rd_row;
    wr_req_t wr_d;

    assign rd_row = rows_q[rd_idx];
    assign rd_ctr = rd_row[rd_sel];

    assign wr_row = rows_q[wr_idx];
    assign wr_cur = wr_row[wr_sel];

    // read-modify-write of one row; only the named slot takes a new value
    always_comb begin
        wr_d             = '0;
        wr_d.en          = wr_en;
        wr_d.idx         = wr_idx;
        wr_d.row         = wr_row;
        wr_d.row[wr_sel] = ctr_next(wr_row[wr_sel], wr_taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                rows_q[i] <= ROW_RST;
            end
        end else if (wr_d.en) begin
            rows_q[wr_d.idx] <= wr_d.row;
        end
    end

endmodule

// File: rtl/bp_corr_predictor.sv
module bp_corr_predictor
    import bp_corr_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int HIST_W  = 2,
    parameter int PC_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PC_W-1:0]            lk_pc,
    output logic                       lk_taken,
    output logic [$clog2(ENTRIES)-1:0] lk_idx,
    output logic [HIST_W-1:0]          lk_hist,
    input  logic                       up_valid,
    input  logic [$clog2(ENTRIES)-1:0] up_idx,
    input  logic [HIST_W-1:0]          up_hist,
    input  logic                       up_taken
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]  idx_w;
    logic [HIST_W-1:0] ghr_w;
    ctr_t              lk_ctr;
    ctr_t              wr_cur;

    bp_corr_index #(
        .PC_W  (PC_W),
        .IDX_W (IDX_W)
    ) u_index (
        .pc  (lk_pc),
        .idx (idx_w)
    );

    bp_corr_history #(
        .HIST_W (HIST_W)
    ) u_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .ghr      (ghr_w)
    );

    bp_corr_table #(
        .ENTRIES (ENTRIES),
        .HIST_W  (HIST_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx_w),
        .rd_sel   (ghr_w),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_sel   (up_hist),
        .wr_taken (up_taken),
        .wr_cur   (wr_cur)
    );

    assign lk_idx   = idx_w;
    assign lk_hist  = ghr_w;
    assign lk_taken = lk_ctr[CTR_W-1];

endmodule

// File: rtl/bp_corr_checker.sv
module bp_corr_checker
    import bp_corr_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic [IDX_W-1:0]  up_idx,
    input logic [HIST_W-1:0] up_hist,
    input logic              up_taken,
    input ctr_t              wr_cur
);

    logic [HIST_W:0] shifted;
    assign shifted = {lk_hist, up_taken};

    // R6: the history takes the resolved outcome at bit 0
    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (lk_hist == $past(shifted[HIST_W-1:0])));

    // R7: no update, no history movement
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R4: a taken update raises the named counter, stopping at the top
    p_ctr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken) |=>
            ((up_idx != $past(up_idx)) || (up_hist != $past(up_hist)) ||
             (wr_cur == (($past(wr_cur) == CTR_MAX) ? CTR_MAX : $past(wr_cur) + ctr_t'(1)))));

    // R4: a not-taken update lowers the named counter, stopping at zero
    p_ctr_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken) |=>
            ((up_idx != $past(up_idx)) || (up_hist != $past(up_hist)) ||
             (wr_cur == (($past(wr_cur) == CTR_MIN) ? CTR_MIN : $past(wr_cur) - ctr_t'(1)))));

    // R7: an idle update port leaves the addressed counter alone
    p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=>
            ((up_idx != $past(up_idx)) || (up_hist != $past(up_hist)) || $stable(wr_cur)));

endmodule

bind bp_corr_predictor bp_corr_checker #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
) u_bp_corr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_hist  (lk_hist),
    .up_valid (up_valid),
    .up_idx   (up_idx),
    .up_hist  (up_hist),
    .up_taken (up_taken),
    .wr_cur   (wr_cur)
);

// File: tb/bp_corr_predictor_test.sv
module bp_corr_predictor_test;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;
    localparam int HIST_W     = 2;
    localparam int PC_W       = 16;
    localparam int IDX_W      = 4;
    localparam int NSLOT      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   lk_pc = '0;
    logic              lk_taken;
    logic [IDX_W-1:0]  lk_idx;
    logic [HIST_W-1:0] lk_hist;
    logic              up_valid = 1'b0;
    logic [IDX_W-1:0]  up_idx = '0;
    logic [HIST_W-1:0] up_hist = '0;
    logic              up_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mdl [ENTRIES][NSLOT];
    int mdl_ghr;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_corr_predictor #(
        .ENTRIES (ENTRIES),
        .HIST_W  (HIST_W),
        .PC_W    (PC_W)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_taken (lk_taken),
        .lk_idx   (lk_idx),
        .lk_hist  (lk_hist),
        .up_valid (up_valid),
        .up_idx   (up_idx),
        .up_hist  (up_hist),
        .up_taken (up_taken)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // R4 / R6 arithmetic model
    task automatic model_update(input int idx, input int hist, input int tk);
        if (tk != 0) begin
            if (mdl[idx][hist] < 3) mdl[idx][hist]++;
        end else begin
            if (mdl[idx][hist] > 0) mdl[idx][hist]--;
        end
        mdl_ghr = ((mdl_ghr << 1) | tk) & (NSLOT - 1);
    endtask

    task automatic do_update(input int idx, input int hist, input int tk);
        @(negedge clk);
        up_valid = 1'b1;
        up_idx   = IDX_W'(idx);
        up_hist  = HIST_W'(hist);
        up_taken = (tk != 0);
        @(negedge clk);
        up_valid = 1'b0;
        model_update(idx, hist, tk);
    endtask

    // drive one lookup; high and low PC bits are varied to show they are ignored (R2)
    task automatic lookup(input int idx);
        lfsr  = step(lfsr);
        lk_pc = PC_W'((int'(lfsr[9:0]) << (IDX_W + 2)) | (idx << 2) | int'(lfsr[11:10]));
        #1;
    endtask

    task automatic probe_all(input string tag);
        for (int i = 0; i < ENTRIES; i++) begin
            lookup(i);
            chk(int'(lk_idx) == i, {"R2 index ", tag}, int'(lk_idx), i);
            chk(int'(lk_hist) == mdl_ghr, {"R6 history ", tag}, int'(lk_hist), mdl_ghr);
            chk(int'(lk_taken) == (mdl[i][mdl_ghr] >= 2 ? 1 : 0),
                {"R3 R5 prediction ", tag}, int'(lk_taken), (mdl[i][mdl_ghr] >= 2 ? 1 : 0));
        end
    endtask

    task automatic expect_pred(input int idx, input int exp, input string req);
        lookup(idx);
        chk(int'(lk_taken) == exp, req, int'(lk_taken), exp);
    endtask

    initial begin
        for (int i = 0; i < ENTRIES; i++)
            for (int j = 0; j < NSLOT; j++)
                mdl[i][j] = 1;
        mdl_ghr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(lk_hist == '0, "R1 history zero", int'(lk_hist), 0);
        probe_all("R1 after reset");

        // R4: saturate slot (3,3) upward; taken updates keep history at 11
        do_update(3, 3, 1);
        do_update(3, 3, 1);
        do_update(3, 3, 1);
        chk(int'(lk_hist) == 3, "R6 history after three taken", int'(lk_hist), 3);
        expect_pred(3, 1, "R4 saturated taken");
        probe_all("R4 up");

        // R8: one miss from strong taken does not flip
        do_update(3, 3, 0);
        do_update(5, 0, 1);
        do_update(5, 0, 1);
        expect_pred(3, 1, "R8 one miss keeps taken");
        probe_all("R8 one miss");

        // R8: second consecutive miss flips
        do_update(3, 3, 0);
        do_update(5, 0, 1);
        do_update(5, 0, 1);
        expect_pred(3, 0, "R8 two misses flip");
        probe_all("R8 two misses");

        // R4: floor at zero, then one taken stays not-taken
        do_update(7, 3, 0);
        do_update(7, 3, 0);
        do_update(9, 1, 1);
        do_update(9, 1, 1);
        expect_pred(7, 0, "R4 floor");
        do_update(7, 3, 1);
        expect_pred(7, 0, "R8 one taken from floor");
        do_update(7, 3, 1);
        expect_pred(7, 1, "R8 second taken from floor");

        // R7: idle update port with live-looking data changes nothing
        @(negedge clk);
        up_valid = 1'b0;
        up_idx   = IDX_W'(7);
        up_hist  = HIST_W'(3);
        up_taken = 1'b0;
        repeat (4) @(negedge clk);
        chk(int'(lk_hist) == mdl_ghr, "R7 history held", int'(lk_hist), mdl_ghr);
        probe_all("R7 idle");

        // R5 R6: pseudo-random sweep; write slot taken from the stream, not the live history
        for (int n = 0; n < 400; n++) begin
            lfsr = step(lfsr);
            do_update(int'(lfsr[3:0]), int'(lfsr[5:4]), int'(lfsr[6] | lfsr[8]));
            probe_all("R5 sweep");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule